// File: doc/BRIEF.md
# Load/Store Register Writeback Arbiter

This block decides, every cycle, which load results from a load/store unit are written into a banked register file. Loads that hit on-chip shared memory go through a short collapsing delay pipe. Responses from the memory system wait in a response queue. The entry at the end of the delay pipe is tried first. The head of the response queue is tried next, and it can only use the banks that the first writer has not taken.

A writeback is all or nothing. Each destination register maps to one bank. The write goes ahead only if every one of those banks is free, meaning it is not busy from outside and not claimed by the higher-priority writer in the same cycle. If any bank is busy, the entry waits where it is. A store completion at the queue head needs no register bank: it is removed at once and signalled to the core as an acknowledgement for its warp.

Top module: `ldst_wb_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no writeback and no store acknowledge are signalled, `bank_wr_o` is zero, `smem_ready_o` is 1 and `rsp_full_o` is 0.
- R2: A shared load offered with `smem_ready_o` high is accepted at that clock edge. With no bank conflict, its writeback appears PIPE_DEPTH clock edges after acceptance. When every stage is occupied and the output entry cannot write, `smem_ready_o` is low and the offer is not taken.
- R3: A blocked output entry holds the delay pipe. Later loads close up behind it, with no gaps left between them. Once the output is unblocked, the stacked loads write back one per cycle on consecutive cycles, in acceptance order.
- R4: When the delay-pipe output and the response-queue head need a common bank, the delay-pipe entry writes in that cycle and the queue entry writes in the next cycle.
- R5: An entry writes only if none of its destination banks is flagged in `bank_busy_i`. Otherwise nothing of it is written (`bank_wr_o` carries none of its banks) and the entry is retained.
- R6: Destination slot d takes register bits [d*REG_W +: REG_W] and is enabled by rmask bit d. Its bank is (register + warp * BANK_WARP_SHIFT) mod NUM_BANKS, and bank b is bit b of the bank vectors.
- R7: `bank_wr_o` equals the union of the banks used by the writebacks signalled in that cycle.
- R8: A store response at the queue head is popped and acknowledged with its warp on `st_ack_o` in the cycle after it was pushed into an empty queue, whatever the state of the banks. It never produces a register writeback.
- R9: `rsp_full_o` is high once the queue holds RSP_DEPTH entries. A push while full is dropped.
- R10: Queue entries, loads and stores alike, complete in push order. A store behind a blocked load is acknowledged only in the cycle after that load writes.
- R11: When the delay-pipe output and the queue head need disjoint free banks, both write back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smem_valid_i | input | 1 | Shared-memory load offered |
| smem_ready_o | output | 1 | Entry stage of the delay pipe can take a load |
| smem_warp_i | input | WARP_W | Warp of the shared load |
| smem_regs_i | input | NUM_DST*REG_W | Destination register numbers |
| smem_rmask_i | input | NUM_DST | Destination slot enables |
| rsp_valid_i | input | 1 | Memory response pushed into the queue |
| rsp_store_i | input | 1 | Response belongs to a store |
| rsp_warp_i | input | WARP_W | Warp of the response |
| rsp_regs_i | input | NUM_DST*REG_W | Destination register numbers |
| rsp_rmask_i | input | NUM_DST | Destination slot enables |
| rsp_full_o | output | 1 | Response queue at capacity |
| bank_busy_i | input | NUM_BANKS | Banks unavailable this cycle |
| smem_wb_o | output | 1 | Delay-pipe output writes this cycle |
| smem_wb_warp_o | output | WARP_W | Warp of that write |
| smem_wb_regs_o | output | NUM_DST*REG_W | Registers of that write |
| smem_wb_rmask_o | output | NUM_DST | Slot enables of that write |
| rsp_wb_o | output | 1 | Queue head writes this cycle |
| rsp_wb_warp_o | output | WARP_W | Warp of that write |
| rsp_wb_regs_o | output | NUM_DST*REG_W | Registers of that write |
| rsp_wb_rmask_o | output | NUM_DST | Slot enables of that write |
| bank_wr_o | output | NUM_BANKS | Banks claimed this cycle |
| st_ack_o | output | 1 | Store acknowledged this cycle |
| st_ack_warp_o | output | WARP_W | Warp of the acknowledged store |

## Verification
The bench builds the block with a six-stage delay pipe, a four-entry queue, four banks, two destination slots and a warp shift of one. Four banks make collisions between small register and warp numbers easy to set up, which lets the bench force shared-versus-queue conflicts and partial bank blocking. A four-entry queue fills within a few pushes, so the dropped push at capacity is reached quickly. A six-stage pipe can be filled completely while its output is blocked, which exposes both the closing-up of entries and the refusal of a new load.

// File: rtl/ldst_wb_pkg.sv
package ldst_wb_pkg;

  // register-file bank of one destination register
  function automatic int unsigned bank_of(input int unsigned reg_num,
                                          input int unsigned warp,
                                          input int unsigned shift,
                                          input int unsigned nbanks);
    return (reg_num + warp * shift) % nbanks;
  endfunction

endpackage

// File: rtl/wb_bank_map.sv
module wb_bank_map
  import ldst_wb_pkg::*;
#(
  parameter int NUM_DST         = 4,
  parameter int REG_W           = 6,
  parameter int WARP_W          = 5,
  parameter int NUM_BANKS       = 8,
  parameter int BANK_WARP_SHIFT = 1
) (
  input  logic [WARP_W-1:0]        warp_i,
  input  logic [NUM_DST*REG_W-1:0] regs_i,
  input  logic [NUM_DST-1:0]       rmask_i,
  output logic [NUM_BANKS-1:0]     need_o
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_DST-1:0][NUM_BANKS-1:0] hit;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [BANK_W-1:0] bank;
    assign bank   = BANK_W'(bank_of(32'(regs_i[d*REG_W +: REG_W]), 32'(warp_i),
                                    BANK_WARP_SHIFT, NUM_BANKS));
    assign hit[d] = rmask_i[d] ? (NUM_BANKS'(1) << bank) : '0;
  end

  always_comb begin
    need_o = '0;
    for (int d = 0; d < NUM_DST; d++) need_o |= hit[d];
  end

endmodule

// File: rtl/wb_delay_pipe.sv
module wb_delay_pipe #(
  parameter int DEPTH = 6,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_take_i
);
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];
  logic [DEPTH-1:0] free;

  // a stage may advance when it or any stage below it opens a hole
  always_comb begin
    free[0] = !vld_q[0] || out_take_i;
    for (int s = 1; s < DEPTH; s++) free[s] = !vld_q[s] || free[s-1];
  end

  assign in_ready_o  = free[DEPTH-1];
  assign out_valid_o = vld_q[0];
  assign out_data_o  = dat_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < DEPTH; s++) dat_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH-1; s++) begin
        if (free[s]) begin
          vld_q[s] <= vld_q[s+1];
          dat_q[s] <= dat_q[s+1];
        end
      end
      if (free[DEPTH-1]) begin
        vld_q[DEPTH-1] <= in_valid_i;
        dat_q[DEPTH-1] <= in_data_i;
      end
    end
  end

  // R2
  accept_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> vld_q[DEPTH-1]);

  // R3
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q[0] && !out_take_i |=> vld_q[0] && $stable(dat_q[0]));

endmodule

// File: rtl/wb_rsp_fifo.sv
module wb_rsp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         full_o,
  output logic         head_valid_o,
  output logic [W-1:0] head_data_o,
  input  logic         pop_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o       = cnt_q >= FULL_CNT;
  assign head_valid_o = cnt_q != '0;
  assign head_data_o  = mem_q[rd_q];
  assign push_ok      = push_i && !full_o;
  assign pop_ok       = pop_i && head_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      end
      if (pop_ok) rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9
  occupancy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);

  // R9
  drop_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(wr_q));

endmodule

// File: rtl/ldst_wb_arbiter.sv
module ldst_wb_arbiter #(
  parameter int PIPE_DEPTH      = 6,
  parameter int RSP_DEPTH       = 4,
  parameter int NUM_DST         = 4,
  parameter int REG_W           = 6,
  parameter int WARP_W          = 5,
  parameter int NUM_BANKS       = 8,
  parameter int BANK_WARP_SHIFT = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smem_valid_i,
  output logic                     smem_ready_o,
  input  logic [WARP_W-1:0]        smem_warp_i,
  input  logic [NUM_DST*REG_W-1:0] smem_regs_i,
  input  logic [NUM_DST-1:0]       smem_rmask_i,
  input  logic                     rsp_valid_i,
  input  logic                     rsp_store_i,
  input  logic [WARP_W-1:0]        rsp_warp_i,
  input  logic [NUM_DST*REG_W-1:0] rsp_regs_i,
  input  logic [NUM_DST-1:0]       rsp_rmask_i,
  output logic                     rsp_full_o,
  input  logic [NUM_BANKS-1:0]     bank_busy_i,
  output logic                     smem_wb_o,
  output logic [WARP_W-1:0]        smem_wb_warp_o,
  output logic [NUM_DST*REG_W-1:0] smem_wb_regs_o,
  output logic [NUM_DST-1:0]       smem_wb_rmask_o,
  output logic                     rsp_wb_o,
  output logic [WARP_W-1:0]        rsp_wb_warp_o,
  output logic [NUM_DST*REG_W-1:0] rsp_wb_regs_o,
  output logic [NUM_DST-1:0]       rsp_wb_rmask_o,
  output logic [NUM_BANKS-1:0]     bank_wr_o,
  output logic                     st_ack_o,
  output logic [WARP_W-1:0]        st_ack_warp_o
);
  localparam int ENT_W = WARP_W + NUM_DST*REG_W + NUM_DST;
  localparam int RSP_W = ENT_W + 1;

  logic                     sm_vld, rs_vld, rs_store, rs_pop;
  logic [ENT_W-1:0]         sm_head;
  logic [RSP_W-1:0]         rs_head;
  logic [WARP_W-1:0]        sm_warp, rs_warp;
  logic [NUM_DST*REG_W-1:0] sm_regs, rs_regs;
  logic [NUM_DST-1:0]       sm_rmask, rs_rmask;
  logic [NUM_BANKS-1:0]     sm_need, rs_need, sm_claim, rs_claim;
  logic                     sm_go, rs_go;

  wb_delay_pipe #(.DEPTH(PIPE_DEPTH), .W(ENT_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (smem_valid_i),
    .in_data_i   ({smem_warp_i, smem_regs_i, smem_rmask_i}),
    .in_ready_o  (smem_ready_o),
    .out_valid_o (sm_vld),
    .out_data_o  (sm_head),
    .out_take_i  (sm_go)
  );

  wb_rsp_fifo #(.DEPTH(RSP_DEPTH), .W(RSP_W)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (rsp_valid_i),
    .push_data_i  ({rsp_store_i, rsp_warp_i, rsp_regs_i, rsp_rmask_i}),
    .full_o       (rsp_full_o),
    .head_valid_o (rs_vld),
    .head_data_o  (rs_head),
    .pop_i        (rs_pop)
  );

  assign {sm_warp, sm_regs, sm_rmask}           = sm_head;
  assign {rs_store, rs_warp, rs_regs, rs_rmask} = rs_head;

  wb_bank_map #(.NUM_DST(NUM_DST), .REG_W(REG_W), .WARP_W(WARP_W),
                .NUM_BANKS(NUM_BANKS), .BANK_WARP_SHIFT(BANK_WARP_SHIFT)) u_sm_map (
    .warp_i  (sm_warp),
    .regs_i  (sm_regs),
    .rmask_i (sm_rmask),
    .need_o  (sm_need)
  );

  wb_bank_map #(.NUM_DST(NUM_DST), .REG_W(REG_W), .WARP_W(WARP_W),
                .NUM_BANKS(NUM_BANKS), .BANK_WARP_SHIFT(BANK_WARP_SHIFT)) u_rs_map (
    .warp_i  (rs_warp),
    .regs_i  (rs_regs),
    .rmask_i (rs_rmask),
    .need_o  (rs_need)
  );

  // shared result first; the queue head sees its banks as taken
  assign sm_go    = sm_vld && ((sm_need & bank_busy_i) == '0);
  assign sm_claim = sm_go ? sm_need : '0;
  assign st_ack_o = rs_vld && rs_store;
  assign rs_go    = rs_vld && !rs_store && ((rs_need & (bank_busy_i | sm_claim)) == '0);
  assign rs_claim = rs_go ? rs_need : '0;
  assign rs_pop   = st_ack_o || rs_go;

  assign bank_wr_o       = sm_claim | rs_claim;
  assign smem_wb_o       = sm_go;
  assign smem_wb_warp_o  = sm_warp;
  assign smem_wb_regs_o  = sm_regs;
  assign smem_wb_rmask_o = sm_rmask;
  assign rsp_wb_o        = rs_go;
  assign rsp_wb_warp_o   = rs_warp;
  assign rsp_wb_regs_o   = rs_regs;
  assign rsp_wb_rmask_o  = rs_rmask;
  assign st_ack_warp_o   = rs_warp;

  // R5
  busy_bank_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_wr_o & bank_busy_i) == '0);

  // R4
  no_shared_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smem_wb_o && rsp_wb_o |-> (u_sm_map.need_o & u_rs_map.need_o) == '0);

  // R8
  ack_not_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ack_o |-> !rsp_wb_o);

endmodule

// File: tb/ldst_wb_arbiter_bench.sv
`timescale 1ns/1ps
module ldst_wb_arbiter_bench;
  localparam int PD = 6, RD = 4, ND = 2, RW = 6, WW = 4, NB = 4, BS = 1;

  typedef struct {
    logic [WW-1:0]    warp;
    logic [ND*RW-1:0] regs;
    logic [ND-1:0]    rmask;
    logic [NB-1:0]    banks;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic smem_valid = 0, rsp_valid = 0, rsp_store = 0;
  logic [WW-1:0] smem_warp = '0, rsp_warp = '0;
  logic [ND*RW-1:0] smem_regs = '0, rsp_regs = '0;
  logic [ND-1:0] smem_rmask = '0, rsp_rmask = '0;
  logic [NB-1:0] bank_busy = '0;
  logic smem_ready_o, rsp_full_o, smem_wb_o, rsp_wb_o, st_ack_o;
  logic [WW-1:0] smem_wb_warp_o, rsp_wb_warp_o, st_ack_warp_o;
  logic [ND*RW-1:0] smem_wb_regs_o, rsp_wb_regs_o;
  logic [ND-1:0] smem_wb_rmask_o, rsp_wb_rmask_o;
  logic [NB-1:0] bank_wr_o;

  ldst_wb_arbiter #(.PIPE_DEPTH(PD), .RSP_DEPTH(RD), .NUM_DST(ND), .REG_W(RW),
                    .WARP_W(WW), .NUM_BANKS(NB), .BANK_WARP_SHIFT(BS)) u_ldst_wb_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .smem_valid_i(smem_valid), .smem_ready_o(smem_ready_o), .smem_warp_i(smem_warp),
    .smem_regs_i(smem_regs), .smem_rmask_i(smem_rmask),
    .rsp_valid_i(rsp_valid), .rsp_store_i(rsp_store), .rsp_warp_i(rsp_warp),
    .rsp_regs_i(rsp_regs), .rsp_rmask_i(rsp_rmask), .rsp_full_o(rsp_full_o),
    .bank_busy_i(bank_busy),
    .smem_wb_o(smem_wb_o), .smem_wb_warp_o(smem_wb_warp_o),
    .smem_wb_regs_o(smem_wb_regs_o), .smem_wb_rmask_o(smem_wb_rmask_o),
    .rsp_wb_o(rsp_wb_o), .rsp_wb_warp_o(rsp_wb_warp_o),
    .rsp_wb_regs_o(rsp_wb_regs_o), .rsp_wb_rmask_o(rsp_wb_rmask_o),
    .bank_wr_o(bank_wr_o), .st_ack_o(st_ack_o), .st_ack_warp_o(st_ack_warp_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  item_t sm_q[$], rs_q[$];
  logic [WW-1:0] ack_q[$];
  int last_sm = -1, last_rs = -1, last_ack = -1, n_sm = 0, n_rs = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic item_t mk(input int w, input int r0, input int r1, input logic [ND-1:0] m);
    item_t it;
    it.warp = WW'(w); it.regs = {RW'(r1), RW'(r0)}; it.rmask = m; it.banks = '0;
    if (m[0]) it.banks[(r0 + w*BS) % NB] = 1'b1;
    if (m[1]) it.banks[(r1 + w*BS) % NB] = 1'b1;
    return it;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [NB-1:0] exp_b;
      item_t it;
      exp_b = '0;
      if (smem_wb_o) begin
        if (sm_q.size() == 0) chk(0, "R3 unexpected shared wb", int'(smem_wb_warp_o), -1);
        else begin
          it = sm_q.pop_front();
          chk(smem_wb_warp_o == it.warp && smem_wb_regs_o == it.regs && smem_wb_rmask_o == it.rmask,
              "R3 shared wb order/content", int'(smem_wb_warp_o), int'(it.warp));
          exp_b |= it.banks;
        end
        last_sm = cyc; n_sm++;
      end
      if (rsp_wb_o) begin
        if (rs_q.size() == 0) chk(0, "R10 unexpected queue wb", int'(rsp_wb_warp_o), -1);
        else begin
          it = rs_q.pop_front();
          chk(rsp_wb_warp_o == it.warp && rsp_wb_regs_o == it.regs && rsp_wb_rmask_o == it.rmask,
              "R10 queue wb order/content", int'(rsp_wb_warp_o), int'(it.warp));
          exp_b |= it.banks;
        end
        last_rs = cyc; n_rs++;
      end
      if (st_ack_o) begin
        if (ack_q.size() == 0) chk(0, "R8 unexpected store ack", int'(st_ack_warp_o), -1);
        else begin
          logic [WW-1:0] w;
          w = ack_q.pop_front();
          chk(st_ack_warp_o == w, "R8 store ack warp", int'(st_ack_warp_o), int'(w));
        end
        last_ack = cyc;
      end
      if (smem_wb_o || rsp_wb_o || bank_wr_o != '0) begin
        chk(bank_wr_o == exp_b, "R7 R6 claimed banks", int'(bank_wr_o), int'(exp_b));
        chk((bank_wr_o & bank_busy) == '0, "R5 busy bank written", int'(bank_wr_o & bank_busy), 0);
      end
    end
  end

  task automatic send_smem(input int w, input int r0, input int r1, input logic [ND-1:0] m,
                           output int c, output bit acc);
    @(negedge clk);
    smem_valid = 1; smem_warp = WW'(w); smem_regs = {RW'(r1), RW'(r0)}; smem_rmask = m;
    c = cyc;
    #1;
    acc = smem_ready_o;
    if (acc) sm_q.push_back(mk(w, r0, r1, m));
    @(posedge clk); #1 smem_valid = 0;
  endtask

  task automatic send_rsp(input bit st, input int w, input int r0, input int r1,
                          input logic [ND-1:0] m, output int c, output bit acc);
    @(negedge clk);
    rsp_valid = 1; rsp_store = st; rsp_warp = WW'(w); rsp_regs = {RW'(r1), RW'(r0)}; rsp_rmask = m;
    c = cyc;
    #1;
    acc = !rsp_full_o;
    if (acc) begin
      if (st) ack_q.push_back(WW'(w));
      else rs_q.push_back(mk(w, r0, r1, m));
    end
    @(posedge clk); #1 rsp_valid = 0;
  endtask

  task automatic set_busy(input logic [NB-1:0] v, output int c);
    @(negedge clk);
    bank_busy = v; c = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int c, x, base;
    bit acc;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk(!smem_wb_o && !rsp_wb_o && !st_ack_o && bank_wr_o == '0, "R1 idle in reset",
        int'(smem_wb_o) + int'(rsp_wb_o) + int'(st_ack_o), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk(smem_ready_o == 1'b1 && rsp_full_o == 1'b0, "R1 ready/full after reset",
        int'({smem_ready_o, rsp_full_o}), 2);
    chk(!smem_wb_o && !rsp_wb_o && !st_ack_o && bank_wr_o == '0, "R1 no output after reset",
        int'(bank_wr_o), 0);

    // R2 latency
    send_smem(1, 2, 3, 2'b11, c, acc);
    chk(acc, "R2 accepted when ready", int'(acc), 1);
    idle(PD + 2);
    chk(last_sm == c + PD, "R2 shared latency", last_sm, c + PD);

    // R3 stacking and drain, R2 refusal when full
    set_busy('1, x);
    for (int k = 0; k < PD; k++) send_smem(k, 0, 0, 2'b01, c, acc);
    idle(3);
    send_smem(9, 1, 0, 2'b01, c, acc);
    chk(!acc, "R2 refuses load when pipe full", int'(acc), 0);
    base = n_sm;
    set_busy('0, x);
    idle(PD + 2);
    chk(n_sm - base == PD, "R3 drained count", n_sm - base, PD);
    chk(last_sm == x + PD - 1, "R3 back-to-back drain", last_sm, x + PD - 1);

    // R4 priority on shared bank 0
    set_busy('1, x);
    send_rsp(0, 2, 2, 0, 2'b01, c, acc);
    send_smem(0, 0, 0, 2'b01, c, acc);
    do @(negedge clk); while (cyc < c + PD);
    bank_busy = '0;
    idle(3);
    chk(last_sm == c + PD, "R4 shared wins", last_sm, c + PD);
    chk(last_rs == c + PD + 1, "R4 queue follows", last_rs, c + PD + 1);

    // R11 disjoint banks in one cycle
    set_busy('1, x);
    send_rsp(0, 1, 0, 0, 2'b01, c, acc);
    send_smem(0, 0, 0, 2'b01, c, acc);
    do @(negedge clk); while (cyc < c + PD);
    bank_busy = '0;
    idle(3);
    chk(last_sm == c + PD && last_rs == c + PD, "R11 both same cycle", last_rs, c + PD);

    // R5 all-or-nothing: warp 3 regs 5,6 -> banks 0,1
    set_busy(4'b0010, x);
    base = n_rs;
    send_rsp(0, 3, 5, 6, 2'b11, c, acc);
    idle(4);
    chk(n_rs == base && bank_wr_o == '0, "R5 blocked by one bank", n_rs - base, 0);
    set_busy(4'b1101, x);
    idle(3);
    chk(n_rs == base, "R6 bank 0 of warp 3 reg 5 blocks", n_rs - base, 0);
    set_busy(4'b1100, x);
    idle(2);
    chk(last_rs == x, "R5 writes once banks free", last_rs, x);

    // R6 warp 2 reg 1 -> bank 3
    set_busy('1, x);
    send_rsp(0, 2, 1, 0, 2'b01, c, acc);
    set_busy(4'b0111, x);
    idle(2);
    chk(last_rs == x, "R6 bank index", last_rs, x);

    // R8 store ack regardless of banks
    set_busy('1, x);
    base = n_rs;
    send_rsp(1, 7, 0, 0, 2'b00, c, acc);
    idle(2);
    chk(last_ack == c + 1, "R8 store ack timing", last_ack, c + 1);
    chk(n_rs == base, "R8 store not written", n_rs - base, 0);

    // R10 store behind blocked load
    last_ack = -1;
    send_rsp(0, 4, 0, 0, 2'b01, c, acc);
    send_rsp(1, 9, 0, 0, 2'b00, c, acc);
    idle(3);
    chk(last_ack == -1, "R10 store waits behind load", last_ack, -1);
    set_busy('0, x);
    idle(3);
    chk(last_rs == x && last_ack == x + 1, "R10 in-order completion", last_ack, x + 1);

    // R9 full and drop
    set_busy('1, x);
    base = n_rs;
    for (int k = 1; k <= RD; k++) send_rsp(0, k, 0, 0, 2'b01, c, acc);
    chk(rsp_full_o == 1'b1, "R9 full at depth", int'(rsp_full_o), 1);
    send_rsp(0, 12, 0, 0, 2'b01, c, acc);
    chk(!acc, "R9 push dropped when full", int'(acc), 0);
    set_busy('0, x);
    idle(RD + 4);
    chk(n_rs - base == RD, "R9 only depth entries drained", n_rs - base, RD);
    chk(rsp_full_o == 1'b0, "R9 not full after drain", int'(rsp_full_o), 0);
    chk(sm_q.size() == 0 && rs_q.size() == 0 && ack_q.size() == 0, "R10 all expected seen",
        sm_q.size() + rs_q.size() + ack_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule